// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-rank SDR SDRAM from power-on to a usable state. After a start pulse it walks a fixed command order on the memory's control pins. It issues a NOP and then holds a stable-clock interval. It precharges all banks and then issues a run of auto-refresh commands. It loads the mode register, raises a done flag and stays there. Every wait is derived at run time from a clock frequency given in kHz and from timing figures given in nanoseconds. Minimum timings use ceiling rounding on the frequency and on the product. The refresh interval is a maximum, so it uses floor rounding on both.

Once the sequence is complete, a refresh interval timer runs continuously. It emits one-cycle refresh requests for the memory controller that takes over the pins. The sequencer issues only NOPs from then on and stays in that state until reset.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: During and after reset, until a start pulse is accepted, the pins show deselect ({cs_n,ras_n,cas_n,we_n} = 1111). In that state CKE = 1, done = 0 and refresh request = 0. CKE stays 1 at all times.
- R2: A start pulse sampled on a clock edge while idle produces a NOP (0111) in the cycle after that edge. Commands use the 4-bit code {cs_n,ras_n,cas_n,we_n}: PRECHARGE = 0010, AUTO REFRESH = 0001, LOAD MODE = 0000. Every cycle between commands shows NOP.
- R3: PRECHARGE ALL follows the opening NOP after Ws+1 cycles, where Ws = ceil(kHz/1000) × STABLE_US, with STABLE_US = 200 by default.
- R4: PRECHARGE ALL drives address bit 10 high. The first AUTO REFRESH follows it after Wrp+1 cycles.
- R5: Exactly N_REF (default 8) AUTO REFRESH commands are issued, Wrc+1 cycles apart. LOAD MODE follows the last one after Wrc+1 cycles.
- R6: During LOAD MODE the address carries the CAS latency in bits 6:4 and zeros elsewhere. This gives burst length 1, sequential bursts, standard operation and programmed write bursts. The bank lines are 0.
- R7: done rises Wmrd+1 cycles after LOAD MODE and stays high until reset.
- R8: Wx = ceil(t_ns × ceil(kHz/1000) / 1000). A zero time gives Wx = 0, so the next command issues in the very next cycle.
- R9: The refresh period is N = floor(t_refi_ns × floor(kHz/1000) / 1000), raised to 1 when it is 0. Refresh requests are single-cycle pulses, the first N cycles after done rises and then every N cycles.
- R10: A start pulse that arrives while the sequence runs, or after done, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| clk_khz_i | input | KHZ_W | Clock frequency in kHz |
| cas_lat_i | input | 3 | CAS latency written into the mode word |
| t_rp_ns_i | input | NS_W | Precharge period, ns |
| t_rc_ns_i | input | NS_W | Refresh-to-refresh period, ns |
| t_mrd_ns_i | input | NS_W | Mode-load settle period, ns |
| t_refi_ns_i | input | NS_W | Refresh interval (maximum), ns |
| sd_cke_o | output | 1 | Clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_addr_o | output | ADDR_W | Address lines |
| sd_ba_o | output | BA_W | Bank lines |
| init_done_o | output | 1 | Sequence complete |
| refresh_req_o | output | 1 | One-cycle refresh request |

## Verification
The bench uses the default parameters: a 13-bit address, 200 µs stable interval and eight refreshes. These keep a full sequence under a thousand cycles at the low frequencies the bench drives. The frequencies are 2.5, 4, 1.001 and 1.5 MHz. They separate the rounded-up from the rounded-down MHz value, so swapped rounding on either path changes the expected schedule. The timing inputs cover zero waits, back-to-back commands, a refresh period clamped to 1, and all eight CAS latency codes. Every command, gap, done edge and refresh pulse is compared against a schedule computed cycle by cycle in the bench.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_DESEL = 4'b1111,
      CMD_NOP   = 4'b0111,
      CMD_PRE   = 4'b0010,
      CMD_REF   = 4'b0001,
      CMD_LMR   = 4'b0000
   } sdr_cmd_e;

   function automatic logic [31:0] mhz_ceil(input logic [31:0] khz);
      return (khz + 32'd999) / 32'd1000;
   endfunction

   function automatic logic [31:0] mhz_floor(input logic [31:0] khz);
      return khz / 32'd1000;
   endfunction

   function automatic logic [31:0] ns_cyc_ceil(input logic [31:0] t_ns,
                                                input logic [31:0] mhz);
      return (t_ns * mhz + 32'd999) / 32'd1000;
   endfunction

   function automatic logic [31:0] ns_cyc_floor(input logic [31:0] t_ns,
                                                 input logic [31:0] mhz);
      return (t_ns * mhz) / 32'd1000;
   endfunction

endpackage

// File: rtl/sdr_timing_conv.sv
module sdr_timing_conv
   import sdram_init_pkg::*;
#(
   parameter int KHZ_W     = 20,
   parameter int NS_W      = 16,
   parameter int CNT_W     = 20,
   parameter int REFI_W    = 24,
   parameter int STABLE_US = 200
) (
   input  logic [KHZ_W-1:0]  clk_khz_i,
   input  logic [NS_W-1:0]   t_rp_ns_i,
   input  logic [NS_W-1:0]   t_rc_ns_i,
   input  logic [NS_W-1:0]   t_mrd_ns_i,
   input  logic [NS_W-1:0]   t_refi_ns_i,
   output logic [CNT_W-1:0]  cyc_stable_o,
   output logic [CNT_W-1:0]  cyc_rp_o,
   output logic [CNT_W-1:0]  cyc_rc_o,
   output logic [CNT_W-1:0]  cyc_mrd_o,
   output logic [REFI_W-1:0] cyc_refi_o
);

   // minimum waits: frequency and product both rounded up
   assign cyc_stable_o = CNT_W'(mhz_ceil(32'(clk_khz_i)) * 32'(STABLE_US));
   assign cyc_rp_o     = CNT_W'(ns_cyc_ceil(32'(t_rp_ns_i),  mhz_ceil(32'(clk_khz_i))));
   assign cyc_rc_o     = CNT_W'(ns_cyc_ceil(32'(t_rc_ns_i),  mhz_ceil(32'(clk_khz_i))));
   assign cyc_mrd_o    = CNT_W'(ns_cyc_ceil(32'(t_mrd_ns_i), mhz_ceil(32'(clk_khz_i))));

   // maximum interval: frequency and product both rounded down
   assign cyc_refi_o   = REFI_W'(ns_cyc_floor(32'(t_refi_ns_i), mhz_floor(32'(clk_khz_i))));

endmodule

// File: rtl/sdr_init_fsm.sv
module sdr_init_fsm
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2,
   parameter int CNT_W  = 20,
   parameter int N_REF  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [2:0]        cas_lat_i,
   input  logic [CNT_W-1:0]  cyc_stable_i,
   input  logic [CNT_W-1:0]  cyc_rp_i,
   input  logic [CNT_W-1:0]  cyc_rc_i,
   input  logic [CNT_W-1:0]  cyc_mrd_i,
   output sdr_cmd_e          cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BA_W-1:0]   ba_o,
   output logic              done_o
);

   localparam int REF_W  = (N_REF > 1) ? $clog2(N_REF) : 1;
   localparam int A10    = 10;
   localparam int CL_LSB = 4;
   localparam int CL_MSB = 6;

   typedef enum logic [2:0] {
      ST_IDLE, ST_STABLE, ST_TRP, ST_TRC, ST_TMRD, ST_DONE
   } seq_st_e;

   seq_st_e           state_q;
   logic [CNT_W-1:0]  wait_q;
   logic [REF_W-1:0]  refs_left_q;
   logic [ADDR_W-1:0] mode_word;
   logic [ADDR_W-1:0] pre_word;

   // mode word: CAS latency field, everything else zero
   for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mode
      if (gi >= CL_LSB && gi <= CL_MSB) begin : g_cl
         assign mode_word[gi] = cas_lat_i[gi-CL_LSB];
      end else begin : g_zero
         assign mode_word[gi] = 1'b0;
      end
      assign pre_word[gi] = (gi == A10);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         cmd_o       <= CMD_DESEL;
         addr_o      <= '0;
         ba_o        <= '0;
         wait_q      <= '0;
         refs_left_q <= '0;
         done_o      <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  cmd_o   <= CMD_NOP;
                  wait_q  <= cyc_stable_i;
                  state_q <= ST_STABLE;
               end
            end
            ST_STABLE: begin
               cmd_o  <= CMD_NOP;
               addr_o <= '0;
               if (wait_q == '0) begin
                  cmd_o   <= CMD_PRE;
                  addr_o  <= pre_word;
                  wait_q  <= cyc_rp_i;
                  state_q <= ST_TRP;
               end else begin
                  wait_q <= wait_q - CNT_W'(1);
               end
            end
            ST_TRP: begin
               cmd_o  <= CMD_NOP;
               addr_o <= '0;
               if (wait_q == '0) begin
                  cmd_o       <= CMD_REF;
                  wait_q      <= cyc_rc_i;
                  refs_left_q <= REF_W'(N_REF - 1);
                  state_q     <= ST_TRC;
               end else begin
                  wait_q <= wait_q - CNT_W'(1);
               end
            end
            ST_TRC: begin
               cmd_o <= CMD_NOP;
               if (wait_q == '0) begin
                  if (refs_left_q == '0) begin
                     cmd_o   <= CMD_LMR;
                     addr_o  <= mode_word;
                     ba_o    <= '0;
                     wait_q  <= cyc_mrd_i;
                     state_q <= ST_TMRD;
                  end else begin
                     cmd_o       <= CMD_REF;
                     wait_q      <= cyc_rc_i;
                     refs_left_q <= refs_left_q - REF_W'(1);
                  end
               end else begin
                  wait_q <= wait_q - CNT_W'(1);
               end
            end
            ST_TMRD: begin
               cmd_o  <= CMD_NOP;
               addr_o <= '0;
               if (wait_q == '0) begin
                  done_o  <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  wait_q <= wait_q - CNT_W'(1);
               end
            end
            default: begin
               cmd_o  <= CMD_NOP;
               addr_o <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
   parameter int REFI_W = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [REFI_W-1:0] period_i,
   output logic              req_o
);

   logic [REFI_W-1:0] cnt_q;
   logic [REFI_W-1:0] reload;

   // a period of zero behaves as a period of one
   assign reload = (period_i == '0) ? '0 : period_i - REFI_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         req_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= reload;
         req_o <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q <= reload;
         req_o <= 1'b1;
      end else begin
         cnt_q <= cnt_q - REFI_W'(1);
         req_o <= 1'b0;
      end
   end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_init_pkg::*;
#(
   parameter int KHZ_W     = 20,
   parameter int NS_W      = 16,
   parameter int ADDR_W    = 13,
   parameter int BA_W      = 2,
   parameter int CNT_W     = 20,
   parameter int REFI_W    = 24,
   parameter int STABLE_US = 200,
   parameter int N_REF     = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [KHZ_W-1:0]  clk_khz_i,
   input  logic [2:0]        cas_lat_i,
   input  logic [NS_W-1:0]   t_rp_ns_i,
   input  logic [NS_W-1:0]   t_rc_ns_i,
   input  logic [NS_W-1:0]   t_mrd_ns_i,
   input  logic [NS_W-1:0]   t_refi_ns_i,
   output logic              sd_cke_o,
   output logic              sd_cs_no,
   output logic              sd_ras_no,
   output logic              sd_cas_no,
   output logic              sd_we_no,
   output logic [ADDR_W-1:0] sd_addr_o,
   output logic [BA_W-1:0]   sd_ba_o,
   output logic              init_done_o,
   output logic              refresh_req_o
);

   // elaboration-time parameter checks
   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must reach bit 10");
   end
   if (CNT_W > 32 || REFI_W > 32) begin : g_bad_cnt
      $error("counter widths are limited to 32 bits");
   end
   if (KHZ_W > 20 || NS_W > 16) begin : g_bad_in
      $error("input widths would overflow the 32-bit conversion");
   end
   if (N_REF < 1) begin : g_bad_ref
      $error("N_REF must be at least 1");
   end

   logic [CNT_W-1:0]  cyc_stable, cyc_rp, cyc_rc, cyc_mrd;
   logic [REFI_W-1:0] cyc_refi;
   sdr_cmd_e          cmd;

   sdr_timing_conv #(
      .KHZ_W(KHZ_W), .NS_W(NS_W), .CNT_W(CNT_W),
      .REFI_W(REFI_W), .STABLE_US(STABLE_US)
   ) u_conv (
      .clk_khz_i    (clk_khz_i),
      .t_rp_ns_i    (t_rp_ns_i),
      .t_rc_ns_i    (t_rc_ns_i),
      .t_mrd_ns_i   (t_mrd_ns_i),
      .t_refi_ns_i  (t_refi_ns_i),
      .cyc_stable_o (cyc_stable),
      .cyc_rp_o     (cyc_rp),
      .cyc_rc_o     (cyc_rc),
      .cyc_mrd_o    (cyc_mrd),
      .cyc_refi_o   (cyc_refi)
   );

   sdr_init_fsm #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W), .N_REF(N_REF)
   ) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .cas_lat_i    (cas_lat_i),
      .cyc_stable_i (cyc_stable),
      .cyc_rp_i     (cyc_rp),
      .cyc_rc_i     (cyc_rc),
      .cyc_mrd_i    (cyc_mrd),
      .cmd_o        (cmd),
      .addr_o       (sd_addr_o),
      .ba_o         (sd_ba_o),
      .done_o       (init_done_o)
   );

   sdr_refresh_timer #(.REFI_W(REFI_W)) u_refi (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (init_done_o),
      .period_i (cyc_refi),
      .req_o    (refresh_req_o)
   );

   assign sd_cke_o = 1'b1;
   assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [2:0]        cas_lat_i,
   input logic              sd_cs_no,
   input logic              sd_ras_no,
   input logic              sd_cas_no,
   input logic              sd_we_no,
   input logic [ADDR_W-1:0] sd_addr_o,
   input logic [BA_W-1:0]   sd_ba_o,
   input logic              init_done_o,
   input logic              refresh_req_o
);

   logic [3:0] pins;
   assign pins = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};

   // R4: precharge-all carries address bit 10
   a_r4_pre_a10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pins == 4'b0010) |-> sd_addr_o[10]);

   // R6: mode word holds only the CAS latency field, bank zero
   a_r6_mode_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pins == 4'b0000) |-> (sd_addr_o == ADDR_W'({cas_lat_i, 4'b0000}) && sd_ba_o == '0));

   // R7: done never drops once raised
   a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_done_o |=> init_done_o);

   // R9: refresh requests only after done
   a_r9_req_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      refresh_req_o |-> init_done_o);

   // R2: only NOPs once the sequence has finished
   a_r2_nop_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_done_o |-> (pins == 4'b0111));

   // R7: done rises only in a NOP cycle following the settle wait
   a_r7_done_rise_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(init_done_o) |-> $past(pins) != 4'b1111);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .cas_lat_i     (cas_lat_i),
   .sd_cs_no      (sd_cs_no),
   .sd_ras_no     (sd_ras_no),
   .sd_cas_no     (sd_cas_no),
   .sd_we_no      (sd_we_no),
   .sd_addr_o     (sd_addr_o),
   .sd_ba_o       (sd_ba_o),
   .init_done_o   (init_done_o),
   .refresh_req_o (refresh_req_o)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_REF      = 8;
   localparam int STABLE_US  = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [19:0] khz = '0;
   logic [2:0]  cas = '0;
   logic [15:0] trp = '0, trc = '0, tmrd = '0, trefi = '0;
   logic        cke, cs_n, ras_n, cas_n, we_n, done, req;
   logic [12:0] addr;
   logic [1:0]  ba;

   int n_chk  = 0;
   int n_fail = 0;

   sdram_pwrup_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clk_khz_i(khz),
      .cas_lat_i(cas), .t_rp_ns_i(trp), .t_rc_ns_i(trc), .t_mrd_ns_i(tmrd),
      .t_refi_ns_i(trefi), .sd_cke_o(cke), .sd_cs_no(cs_n), .sd_ras_no(ras_n),
      .sd_cas_no(cas_n), .sd_we_no(we_n), .sd_addr_o(addr), .sd_ba_o(ba),
      .init_done_o(done), .refresh_req_o(req)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic check(input bit ok, input string req_tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req_tag, act, exp);
      end
   endtask

   task automatic run_cfg(input int k, input int cl, input int p, input int c,
                          input int m, input int f, input bit inject);
      int mu, md, ws, wrp, wrc, wmrd, nref, c_pre, c_ref0, c_lmr, c_done, last;
      int gap_bad, done_bad, req_bad, first_bad;
      mu   = (k + 999) / 1000;
      md   = k / 1000;
      ws   = mu * STABLE_US;
      wrp  = (p * mu + 999) / 1000;
      wrc  = (c * mu + 999) / 1000;
      wmrd = (m * mu + 999) / 1000;
      nref = (f * md) / 1000;
      if (nref == 0) nref = 1;
      c_pre  = ws + 1;
      c_ref0 = c_pre + wrp + 1;
      c_lmr  = c_ref0 + N_REF * (wrc + 1);
      c_done = c_lmr + wmrd + 1;
      last   = c_done + 3 * nref + 2;

      rst_n = 1'b0; start = 1'b0;
      khz = 20'(k); cas = 3'(cl); trp = 16'(p); trc = 16'(c); tmrd = 16'(m); trefi = 16'(f);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check({cs_n, ras_n, cas_n, we_n, cke, done, req} == 7'b1111100, "R1 reset",
            int'({cs_n, ras_n, cas_n, we_n, cke, done, req}), 7'b1111100);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1: idle without start
      check({cs_n, ras_n, cas_n, we_n, cke, done} == 6'b111110, "R1 idle",
            int'({cs_n, ras_n, cas_n, we_n, cke, done}), 6'b111110);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;

      gap_bad = 0; done_bad = 0; req_bad = 0; first_bad = 0;
      for (int cyc = 0; cyc <= last; cyc++) begin
         logic [3:0] pins, ecmd;
         bool_ev: begin end
         if (cyc > 0) begin
            @(negedge clk);
            start = 1'b0;
         end
         pins = {cs_n, ras_n, cas_n, we_n};
         ecmd = 4'b0111;
         if (cyc == c_pre) ecmd = 4'b0010;
         if (cyc == c_lmr) ecmd = 4'b0000;
         for (int r = 0; r < N_REF; r++)
            if (cyc == c_ref0 + r * (wrc + 1)) ecmd = 4'b0001;
         if (cyc == 0)
            check(pins == 4'b0111, "R2 first NOP", pins, 4'b0111);
         else if (cyc == c_pre) begin
            check(pins == 4'b0010, "R3 precharge time", pins, 4'b0010);
            check(addr[10] == 1'b1, "R4 A10 on precharge", addr[10], 1);
         end else if (cyc == c_lmr) begin
            check(pins == 4'b0000, "R5 mode load time", pins, 4'b0000);
            check(addr == 13'(cl << 4) && ba == 2'b00, "R6 mode word",
                  int'({ba, addr}), cl << 4);
         end else if (ecmd == 4'b0001)
            check(pins == 4'b0001, "R5 R8 refresh time", pins, 4'b0001);
         else if (pins != 4'b0111 || cke != 1'b1) begin
            gap_bad++;
            if (gap_bad == 1)
               $display("FAIL R2 R10 gap at cycle %0d: actual=%0d expected=%0d", cyc, pins, 7);
         end
         if (done != (cyc >= c_done)) done_bad++;
         if (req != (cyc > c_done && ((cyc - c_done) % nref) == 0)) begin
            req_bad++;
            if (cyc <= c_done + nref) first_bad++;
         end
         if (inject && (cyc == 4 || cyc == c_done + 1)) start = 1'b1;
      end
      n_chk++;
      if (gap_bad != 0) n_fail++;
      check(done_bad == 0, "R7 done timing", done_bad, 0);
      check(first_bad == 0, "R9 first refresh request", first_bad, 0);
      check(req_bad == 0, "R9 refresh period", req_bad, 0);
   endtask

   initial begin
      // ceil/floor MHz differ (3 vs 2): multi-cycle waits, period 31
      run_cfg(2500, 2, 700, 2100, 400, 15600, 1'b0);
      // zero waits, period 1, restart pulses ignored (R10, R8)
      run_cfg(4000, 3, 0, 0, 0, 250, 1'b1);
      // MHz 2 vs 1, refresh product rounds to 0 and clamps to 1
      run_cfg(1001, 1, 1000, 1499, 1, 999, 1'b1);
      // every CAS latency code
      for (int cl = 0; cl < 8; cl++)
         run_cfg(1500, cl, 500, 1000, 300, 5000, cl[0]);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule